// File: doc/BRIEF.md
# Fast-Page DRAM Access Controller

This block sits between an on-chip requester and an asynchronous 16-bit DRAM with a 9-bit multiplexed address bus and separate upper-byte and lower-byte column strobes. It accepts word-level read and write requests through a valid/ready handshake and turns each one into a strobe sequence. Every timing figure is a count of system clock cycles, set by a parameter.

After a row is opened, that row stays active. A later request to the same row runs only a column cycle. A request to another row first precharges the old row and then opens the new one. A two-bit byte mask drives the two column strobes independently. Writes are always early writes, with write enable low before any strobe falls. Read data is registered at the end of the column pulse and returned as a one-cycle response.

A row that stays open too long is closed automatically before the row-strobe limit is reached. An external refresh request closes the open page and then runs a column-before-row refresh. A request is accepted on a cycle where `req_valid` and `req_ready` are both high. `req_valid` must not depend on `req_ready`. The response path has no back-pressure: `rsp_valid` is a single-cycle pulse that the consumer must take.

Top module: `pgdram_ctrl`

## Requirements
- R1: An 18-bit request address is split into a row part (`req_addr[17:9]`) and a column part (`req_addr[8:0]`). The row part is on `dr_addr` when `dr_ras_n` falls, and the column part is on `dr_addr` when a column strobe falls.
- R2: Byte-mask bit 1 controls `dr_ucas_n` (data bits 15:8) and bit 0 controls `dr_lcas_n` (bits 7:0), with 1 meaning enabled. A disabled byte is never strobed and reads back as zero. With mask 00, no column strobe falls.
- R3: When a request hits the open row, the controller runs a column cycle without a new `dr_ras_n` fall. A read returns `rsp_valid` 2+T_CAS cycles after acceptance.
- R4: When a request misses the open row, `dr_ras_n` is raised for T_RP cycles and the new row is opened. The read latency is then 2+T_RP+T_RCD+T_CAS cycles. When no page is open, the read latency is 2+T_RCD+T_CAS cycles.
- R5: In a write, `dr_we_n` is low at least one cycle before the column strobe falls. `dr_oe_n` stays high and the controller drives the data bus.
- R6: In a read, `dr_oe_n` is low and `dr_we_n` is high. The data is captured on the last column-pulse cycle, and `rsp_valid` pulses for exactly one cycle.
- R7: Between two column pulses in one page, both column strobes stay high for at least T_CP cycles.
- R8: `dr_ras_n` is never low for more than RAS_LIM consecutive cycles. An idle page is closed automatically.
- R9: While `ref_req` is high, `req_ready` is low. A refresh starts only after the page is closed. In a refresh, both column strobes go low T_CSR cycles before `dr_ras_n` falls, and `ref_done` pulses once at the end of the refresh.
- R10: After reset, all strobes are high, `dr_dq_oe` and `rsp_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 18 | Word address, row in the upper 9 bits |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Byte enables: bit 1 is the upper byte, bit 0 the lower |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_data | output | 16 | Read data, with disabled bytes set to zero |
| ref_req | input | 1 | Refresh wanted; hold high until `ref_done` |
| ref_done | output | 1 | Refresh finished |
| dr_addr | output | 9 | Multiplexed DRAM address |
| dr_ras_n | output | 1 | Row strobe, active low |
| dr_ucas_n | output | 1 | Upper-byte column strobe, active low |
| dr_lcas_n | output | 1 | Lower-byte column strobe, active low |
| dr_we_n | output | 1 | Write enable, active low |
| dr_oe_n | output | 1 | Output enable, active low |
| dr_dq_out | output | 16 | Data driven toward the DRAM |
| dr_dq_oe | output | 1 | Drive enable for `dr_dq_out` |
| dr_dq_in | input | 16 | Data returned by the DRAM |

## Verification
Read results come on a fixed schedule counted from the acceptance edge. They arrive after 2+T_CAS cycles on a page hit, 2+T_RCD+T_CAS cycles from a closed page, and 2+T_RP+T_RCD+T_CAS cycles on a row miss. After `ref_req` rises with a page open, `ref_done` is due T_RP+1+T_CSR+T_RFR+T_RP cycles later. The bench samples half a cycle after each edge and counts those half-cycle points against the expected figure. A small DRAM model records each strobe fall, so addresses, lanes and write data are compared against what the pins carried at that moment.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ROW,
    ST_CSET,
    ST_COL,
    ST_CPRE,
    ST_OPEN,
    ST_CLOSE,
    ST_RCSR,
    ST_RRAS,
    ST_RPRE
  } pg_state_e;
endpackage

// File: rtl/pgdram_timer.sv
// Down-counter for state dwell times: a state loaded with N-1 lasts N cycles.
module pgdram_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/pgdram_rasage.sv
// Counts how long the row strobe has been low and flags a page as stale
// early enough that one more column cycle still ends inside the limit.
module pgdram_rasage #(
  parameter int LIMIT = 12000,
  parameter int GUARD = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic row_open,
  output logic page_old
);
  localparam int OLD_AT = LIMIT - GUARD;
  localparam int CW     = $clog2(LIMIT + 1);

  logic [CW-1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   age <= '0;
    else if (!row_open)           age <= '0;
    else if (age < CW'(OLD_AT))   age <= age + 1'b1;
  end

  assign page_old = (age >= CW'(OLD_AT));
endmodule

// File: rtl/pgdram_lane.sv
// One byte lane: its column strobe and its read-capture register.
module pgdram_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         col_on,
  input  logic         cbr_on,
  input  logic         capture,
  input  logic [W-1:0] dq_lane,
  output logic         cas_n,
  output logic [W-1:0] rd_lane
);
  assign cas_n = !((col_on && en) || cbr_on);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_lane <= '0;
    else if (capture) rd_lane <= en ? dq_lane : '0;
  end
endmodule

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl
  import pgdram_pkg::*;
#(
  parameter int ROW_W   = 9,
  parameter int COL_W   = 9,
  parameter int DATA_W  = 16,
  parameter int T_RCD   = 2,
  parameter int T_CAS   = 2,
  parameter int T_CP    = 1,
  parameter int T_RP    = 4,
  parameter int T_CSR   = 1,
  parameter int T_RFR   = 5,
  parameter int RAS_LIM = 12000,
  parameter int TMR_W   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [1:0]             req_bmask,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_data,
  input  logic                   ref_req,
  output logic                   ref_done,
  output logic [ROW_W-1:0]       dr_addr,
  output logic                   dr_ras_n,
  output logic                   dr_ucas_n,
  output logic                   dr_lcas_n,
  output logic                   dr_we_n,
  output logic                   dr_oe_n,
  output logic [DATA_W-1:0]      dr_dq_out,
  output logic                   dr_dq_oe,
  input  logic [DATA_W-1:0]      dr_dq_in
);
  localparam int LANES  = 2;
  localparam int LANE_W = DATA_W / LANES;
  localparam int GUARD  = T_CAS + T_CP + 3;

  pg_state_e st, st_n;
  logic pend, pend_n;
  logic tload, t_zero, accept, page_old, ras_low, capture;
  logic [TMR_W-1:0] tval;
  logic cur_write;
  logic [ROW_W-1:0] cur_row;
  logic [COL_W-1:0] cur_col;
  logic [DATA_W-1:0] cur_wdata;
  logic [LANES-1:0] cur_mask;
  logic [LANES-1:0] lane_cas_n;
  logic [LANES-1:0][LANE_W-1:0] lane_rd;
  logic col_on, cbr_on, xfer_on;
  logic [ROW_W-1:0] req_row;

  assign req_row = req_addr[ROW_W+COL_W-1:COL_W];

  // Request acceptance: refresh has priority and a stale page takes no more work.
  assign req_ready = !ref_req && ((st == ST_IDLE) || (st == ST_OPEN && !page_old));

  always_comb begin
    st_n   = st;
    pend_n = pend;
    tload  = 1'b0;
    tval   = '0;
    accept = 1'b0;
    case (st)
      ST_IDLE: begin
        if (ref_req) begin
          st_n = ST_RCSR; tload = 1'b1; tval = TMR_W'(T_CSR - 1);
        end else if (req_valid) begin
          accept = 1'b1; st_n = ST_ROW; tload = 1'b1; tval = TMR_W'(T_RCD - 1);
        end
      end
      ST_ROW:  if (t_zero) begin st_n = ST_CSET; tload = 1'b1; tval = '0; end
      ST_CSET: if (t_zero) begin st_n = ST_COL;  tload = 1'b1; tval = TMR_W'(T_CAS - 1); end
      ST_COL:  if (t_zero) begin st_n = ST_CPRE; tload = 1'b1; tval = TMR_W'(T_CP - 1); end
      ST_CPRE: if (t_zero) st_n = ST_OPEN;
      ST_OPEN: begin
        if (ref_req || page_old) begin
          st_n = ST_CLOSE; tload = 1'b1; tval = TMR_W'(T_RP - 1); pend_n = 1'b0;
        end else if (req_valid) begin
          accept = 1'b1;
          if (req_row == cur_row) begin
            st_n = ST_CSET; tload = 1'b1; tval = '0;
          end else begin
            st_n = ST_CLOSE; tload = 1'b1; tval = TMR_W'(T_RP - 1); pend_n = 1'b1;
          end
        end
      end
      ST_CLOSE: begin
        if (t_zero) begin
          if (pend) begin
            st_n = ST_ROW; tload = 1'b1; tval = TMR_W'(T_RCD - 1); pend_n = 1'b0;
          end else begin
            st_n = ST_IDLE;
          end
        end
      end
      ST_RCSR: if (t_zero) begin st_n = ST_RRAS; tload = 1'b1; tval = TMR_W'(T_RFR - 1); end
      ST_RRAS: if (t_zero) begin st_n = ST_RPRE; tload = 1'b1; tval = TMR_W'(T_RP - 1); end
      ST_RPRE: if (t_zero) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      pend      <= 1'b0;
      cur_write <= 1'b0;
      cur_row   <= '0;
      cur_col   <= '0;
      cur_wdata <= '0;
      cur_mask  <= '0;
      rsp_valid <= 1'b0;
    end else begin
      st        <= st_n;
      pend      <= pend_n;
      rsp_valid <= capture;
      if (accept) begin
        cur_write <= req_write;
        cur_row   <= req_row;
        cur_col   <= req_addr[COL_W-1:0];
        cur_wdata <= req_wdata;
        cur_mask  <= req_bmask;
      end
    end
  end

  pgdram_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tload), .load_val(tval), .expired(t_zero)
  );

  assign ras_low = (st == ST_ROW) || (st == ST_CSET) || (st == ST_COL) ||
                   (st == ST_CPRE) || (st == ST_OPEN) || (st == ST_RRAS);

  pgdram_rasage #(.LIMIT(RAS_LIM), .GUARD(GUARD)) u_age (
    .clk(clk), .rst_n(rst_n), .row_open(ras_low), .page_old(page_old)
  );

  assign col_on  = (st == ST_COL);
  assign cbr_on  = (st == ST_RCSR) || (st == ST_RRAS);
  assign xfer_on = (st == ST_CSET) || (st == ST_COL);
  assign capture = col_on && t_zero && !cur_write;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pgdram_lane #(.W(LANE_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .en(cur_mask[g]), .col_on(col_on),
      .cbr_on(cbr_on), .capture(capture),
      .dq_lane(dr_dq_in[g*LANE_W +: LANE_W]),
      .cas_n(lane_cas_n[g]), .rd_lane(lane_rd[g])
    );
  end

  assign rsp_data  = lane_rd;
  assign dr_ucas_n = lane_cas_n[1];
  assign dr_lcas_n = lane_cas_n[0];
  assign dr_ras_n  = !ras_low;
  assign dr_addr   = (st == ST_CSET || st == ST_COL || st == ST_CPRE) ?
                     ROW_W'(cur_col) : cur_row;
  assign dr_we_n   = !(xfer_on && cur_write);
  assign dr_oe_n   = !(xfer_on && !cur_write);
  assign dr_dq_oe  = xfer_on && cur_write;
  assign dr_dq_out = cur_wdata;
  assign ref_done  = (st == ST_RPRE) && t_zero;
endmodule

// File: rtl/pgdram_chk.sv
module pgdram_chk #(
  parameter int T_CP    = 1,
  parameter int RAS_LIM = 12000
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic ref_req,
  input logic rsp_valid,
  input logic dr_ras_n,
  input logic dr_ucas_n,
  input logic dr_lcas_n,
  input logic dr_we_n,
  input logic dr_oe_n,
  input logic dr_dq_oe
);
  localparam int RW = $clog2(RAS_LIM + 2);

  logic cas_any_n;
  logic [RW-1:0] ras_run;
  logic [7:0] hi_run;

  assign cas_any_n = dr_ucas_n & dr_lcas_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_run <= '0;
      hi_run  <= '0;
    end else begin
      ras_run <= dr_ras_n ? '0 : ((ras_run < RW'(RAS_LIM + 1)) ? ras_run + 1'b1 : ras_run);
      hi_run  <= !cas_any_n ? '0 : ((hi_run != 8'hFF) ? hi_run + 1'b1 : hi_run);
    end
  end

  AST_NO_OE_WE_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dr_oe_n && !dr_we_n)); // R6
  AST_WE_BEFORE_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_any_n) && !dr_ras_n && !dr_we_n) |-> $past(!dr_we_n)); // R5
  AST_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dr_dq_oe |-> (!dr_we_n && dr_oe_n)); // R5
  AST_RAS_WITHIN_LIM: assert property (@(posedge clk) disable iff (!rst_n)
    !dr_ras_n |-> (ras_run < RW'(RAS_LIM))); // R8
  AST_CAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_any_n) && !dr_ras_n && $past(!dr_ras_n)) |-> (hi_run >= 8'(T_CP))); // R7
  AST_REF_HOLDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !req_ready); // R9
  AST_CAS_LEADS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dr_ras_n) && !cas_any_n) |-> $past(!cas_any_n)); // R9
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R6
endmodule

bind pgdram_ctrl pgdram_chk #(.T_CP(T_CP), .RAS_LIM(RAS_LIM)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .ref_req(ref_req),
  .rsp_valid(rsp_valid), .dr_ras_n(dr_ras_n), .dr_ucas_n(dr_ucas_n),
  .dr_lcas_n(dr_lcas_n), .dr_we_n(dr_we_n), .dr_oe_n(dr_oe_n),
  .dr_dq_oe(dr_dq_oe)
);

// File: tb/pgdram_ctrl_tb.sv
`timescale 1ns/1ps
module pgdram_ctrl_tb;
  localparam int T_RCD = 2, T_CAS = 2, T_CP = 1, T_RP = 3, T_CSR = 1, T_RFR = 5;
  localparam int RAS_LIM = 80;
  localparam int NV = 10;
  // {write, row[8:0], col[8:0], data[15:0], mask[1:0], kind[1:0]}
  // kind: 0 = page hit, 1 = open from closed page, 2 = row miss
  localparam logic [38:0] VEC [NV] = '{
    {1'b1, 9'h012, 9'h005, 16'hA1B2, 2'b11, 2'd1},
    {1'b0, 9'h012, 9'h005, 16'h0000, 2'b11, 2'd0},
    {1'b1, 9'h012, 9'h1FF, 16'h1234, 2'b10, 2'd0},
    {1'b1, 9'h012, 9'h100, 16'h5678, 2'b01, 2'd0},
    {1'b0, 9'h012, 9'h0AA, 16'h0000, 2'b10, 2'd0},
    {1'b0, 9'h1FF, 9'h000, 16'h0000, 2'b11, 2'd2},
    {1'b0, 9'h1FF, 9'h1FF, 16'h0000, 2'b01, 2'd0},
    {1'b1, 9'h000, 9'h000, 16'hFFFF, 2'b11, 2'd2},
    {1'b1, 9'h000, 9'h033, 16'hBEEF, 2'b00, 2'd0},
    {1'b0, 9'h000, 9'h033, 16'h0000, 2'b00, 2'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_bmask = '0;
  logic req_ready, rsp_valid, ref_done;
  logic [15:0] rsp_data, dr_dq_out, dr_dq_in;
  logic [8:0] dr_addr;
  logic dr_ras_n, dr_ucas_n, dr_lcas_n, dr_we_n, dr_oe_n, dr_dq_oe;

  pgdram_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP),
                .T_CSR(T_CSR), .T_RFR(T_RFR), .RAS_LIM(RAS_LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_bmask(req_bmask), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ref_req(ref_req), .ref_done(ref_done), .dr_addr(dr_addr),
    .dr_ras_n(dr_ras_n), .dr_ucas_n(dr_ucas_n), .dr_lcas_n(dr_lcas_n),
    .dr_we_n(dr_we_n), .dr_oe_n(dr_oe_n), .dr_dq_out(dr_dq_out),
    .dr_dq_oe(dr_dq_oe), .dr_dq_in(dr_dq_in)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  function automatic logic [15:0] pat(input logic [8:0] r, input logic [8:0] c);
    return {r[7:0] ^ {7'd0, c[8]}, c[7:0] ^ {7'd0, r[8]}} ^ 16'h5A3C;
  endfunction

  // DRAM pin model: records what the pins carry at each strobe fall.
  logic [8:0] m_row = '0, m_col = '0, w_row = '0, w_col = '0;
  logic [15:0] w_data = '0;
  logic [1:0] w_lanes = '0;
  logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1;
  int ras_falls = 0, cbr_falls = 0, wr_cnt = 0;
  int ras_run = 0, max_ras_run = 0, cas_hi = 0, min_cas_hi = 999;
  bit early_bad = 0, read_bad = 0;

  assign dr_dq_in = pat(m_row, m_col);

  always @(negedge clk) begin
    logic cas_any;
    cas_any = dr_ucas_n & dr_lcas_n;
    if (rst_n) begin
      if (p_ras && !dr_ras_n) begin
        m_row = dr_addr;
        if (!cas_any) cbr_falls++; else ras_falls++;
      end
      if (p_cas && !cas_any && !dr_ras_n && !p_ras) begin
        m_col = dr_addr;
        if (cas_hi < min_cas_hi) min_cas_hi = cas_hi;
        if (!dr_we_n) begin
          wr_cnt++;
          w_row = m_row; w_col = dr_addr; w_data = dr_dq_out;
          w_lanes = {!dr_ucas_n, !dr_lcas_n};
          if (p_we || !dr_dq_oe || !dr_oe_n) early_bad = 1;
        end else if (dr_oe_n) begin
          read_bad = 1;
        end
      end
      cas_hi  = cas_any ? cas_hi + 1 : 0;
      ras_run = dr_ras_n ? 0 : ras_run + 1;
      if (ras_run > max_ras_run) max_ras_run = ras_run;
    end
    p_ras = dr_ras_n; p_cas = cas_any; p_we = dr_we_n;
  end

  task automatic do_req(input logic wr, input logic [8:0] row, input logic [8:0] col,
                        input logic [15:0] d, input logic [1:0] m, input int kind);
    int rf0, wc0, k, lat, g;
    logic [15:0] exp;
    rf0 = ras_falls; wc0 = wr_cnt;
    req_valid = 1'b1; req_write = wr; req_addr = {row, col}; req_wdata = d; req_bmask = m;
    g = 0;
    while (!req_ready && g < 100) begin tick(); g++; end
    tick();
    req_valid = 1'b0;
    k = 1;
    lat = 2 + T_CAS + ((kind >= 1) ? T_RCD : 0) + ((kind == 2) ? T_RP : 0);
    if (!wr) begin
      while (!rsp_valid && k < 60) begin tick(); k++; end
      chk(k == lat, (kind == 0) ? "R3 hit latency" : "R4 open latency", k, lat);
      exp = pat(row, col) & {{8{m[1]}}, {8{m[0]}}};
      chk(rsp_data == exp, "R2 R6 read data", rsp_data, exp);
      chk(!read_bad, "R6 read strobes", read_bad, 0);
      if (m != 2'b00) chk(m_row == row && m_col == col, "R1 read address", {m_row, m_col}, {row, col});
    end
    g = 0;
    while (!req_ready && g < 100) begin tick(); g++; end
    if (wr) begin
      if (m != 2'b00) begin
        chk(wr_cnt == wc0 + 1, "R5 write issued", wr_cnt, wc0 + 1);
        chk(w_row == row && w_col == col, "R1 write address", {w_row, w_col}, {row, col});
        chk(w_lanes == m, "R2 write lanes", w_lanes, m);
        chk(w_data == d, "R5 write data", w_data, d);
        chk(!early_bad, "R5 early write", early_bad, 0);
      end else begin
        chk(wr_cnt == wc0, "R2 empty mask no strobe", wr_cnt, wc0);
      end
    end
    chk((ras_falls - rf0) == ((kind != 0) ? 1 : 0), (kind == 0) ? "R3 no reopen" : "R4 reopen",
        ras_falls - rf0, (kind != 0) ? 1 : 0);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int k, bad;
    repeat (4) tick();
    rst_n = 1'b1;
    tick();
    // R10 reset state
    chk(dr_ras_n && dr_ucas_n && dr_lcas_n, "R10 strobes idle", {dr_ras_n, dr_ucas_n, dr_lcas_n}, 3'b111);
    chk(dr_we_n && dr_oe_n && !dr_dq_oe, "R10 controls idle", {dr_we_n, dr_oe_n, dr_dq_oe}, 3'b110);
    chk(req_ready && !rsp_valid, "R10 handshake idle", {req_ready, rsp_valid}, 2'b10);

    for (int i = 0; i < NV; i++)
      do_req(VEC[i][38], VEC[i][37:29], VEC[i][28:20], VEC[i][19:4], VEC[i][3:2], int'(VEC[i][1:0]));

    // R9 refresh with a page open
    ref_req = 1'b1;
    #0;
    chk(!req_ready, "R9 ready drops", req_ready, 0);
    tick();
    chk(dr_ras_n, "R9 page closed first", dr_ras_n, 1);
    k = 1; bad = 0;
    while (!ref_done && k < 60) begin
      if (req_ready) bad++;
      tick(); k++;
    end
    chk(k == T_RP + 1 + T_CSR + T_RFR + T_RP, "R9 refresh length", k, T_RP + 1 + T_CSR + T_RFR + T_RP);
    chk(bad == 0, "R9 ready low during refresh", bad, 0);
    chk(cbr_falls == 1, "R9 column-first refresh", cbr_falls, 1);
    ref_req = 1'b0;
    tick();
    chk(req_ready, "R9 ready back", req_ready, 1);

    // R8 page closed by the open-time limit
    do_req(1'b0, 9'h000, 9'h007, 16'h0, 2'b11, 1);
    repeat (150) tick();
    chk(dr_ras_n, "R8 idle page closed", dr_ras_n, 1);
    chk(max_ras_run <= RAS_LIM, "R8 row strobe limit", max_ras_run, RAS_LIM);
    do_req(1'b0, 9'h000, 9'h008, 16'h0, 2'b11, 1);
    chk(min_cas_hi >= T_CP, "R7 column precharge", min_cas_hi, T_CP);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule